// File: doc/BRIEF.md
# Nibble-Symbol Chipkill ECC Codec

This block guards a 32-bit memory word against the total loss of one 4-bit-wide DRAM device. Every nibble of the stored word is handled as one symbol of a Reed-Solomon code over GF(16). The field polynomial is x^4 + x + 1, and the generator polynomial has roots alpha^0, alpha^1 and alpha^2. Eight data symbols and three check symbols make an 11-symbol, 44-bit codeword with minimum symbol distance 4.

The write side is purely combinational. It places the data word unchanged in the upper part of the codeword and computes the three check symbols below it, so data and check bits go to memory together in one word.

The read side computes three syndromes and works out the location and value of a single-symbol error. A result comes out of one register stage, one cycle after the codeword is presented:
- A correctable word is returned already repaired, with no retry.
- Errors that span two symbols are reported and are never miscorrected.

Top module: `ck_codec`

## Requirements
- R1: The codeword is systematic. Bits [43:12] equal the data word, so data nibble i sits at symbol position i+3. Bits [11:0] hold check symbols 0..2, with symbol p at bits [4p+3:4p]. The encoder output follows its input in the same cycle.
- R2: The encoder is linear over XOR: code(a^b) = code(a)^code(b), and all-zero data gives an all-zero codeword.
- R3: A codeword produced by the encoder decodes with both flags low, symbol index 0, and the original data.
- R4: Any nonzero error confined to one data nibble is repaired. This includes all four bits flipped. The corrected flag rises and the symbol index gives the failing position (3..10).
- R5: An error confined to one check symbol sets the corrected flag with the index 0..2 and leaves the delivered data equal to the original data.
- R6: Any error with nonzero values in two different symbols sets the uncorrectable flag. The corrected flag and the index stay 0, and the data output is the received data field unmodified.
- R7: The result valid output rises exactly one cycle after a codeword valid input. Data, flags and index change only on a cycle that follows a valid input.
- R8: After synchronous reset, result valid, both flags, the index and the data output are all 0.
- R9: The corrected and uncorrectable flags are never high together. The index is nonzero only while the corrected flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data_i | input | 32 | Data word to be written |
| enc_code_o | output | 44 | Codeword to store (combinational) |
| dec_valid_i | input | 1 | Codeword on dec_code_i is valid this cycle |
| dec_code_i | input | 44 | Codeword read from memory |
| dec_valid_o | output | 1 | Decode result valid |
| dec_data_o | output | 32 | Repaired data word |
| dec_corr_o | output | 1 | A single-symbol error was corrected |
| dec_uncorr_o | output | 1 | Error beyond one symbol detected |
| dec_sym_o | output | 4 | Position of the corrected symbol (0..10) |

## Verification
The encoder has no register, so its output is read one time step after a new data word is applied, within the same clock period. Every decode result, including the valid output, the data, both flags and the index, is registered once. The bench therefore presents a codeword on a falling edge, drops the valid input on the next falling edge, and samples all decode outputs at that second falling edge, just after the capturing rising edge. One further falling edge later it confirms that valid is low and the data and flags are held.

// File: rtl/ck_pkg.sv
package ck_pkg;
  localparam int SYM_W    = 4;   // bits per symbol, one x4 device
  localparam int CHK_SYMS = 3;   // check symbols, distance 4

  // GF(16) multiply, field polynomial x^4 + x + 1
  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p;
    logic [3:0] x;
    p = 4'h0;
    x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  // alpha^e with alpha = 2
  function automatic logic [3:0] gf_apow(input int e);
    logic [3:0] r;
    r = 4'h1;
    for (int i = 0; i < (e % 15); i++) r = gf_mul(r, 4'h2);
    return r;
  endfunction

  // inverse as a^14 (0 maps to 0)
  function automatic logic [3:0] gf_inv(input logic [3:0] a);
    logic [3:0] r;
    r = 4'h1;
    for (int i = 0; i < 14; i++) r = gf_mul(r, a);
    return r;
  endfunction

  // generator (x+1)(x+alpha)(x+alpha^2) = x^3 + 7x^2 + 14x + 8
  localparam logic [3:0] GEN2 = 4'h7;
  localparam logic [3:0] GEN1 = 4'he;
  localparam logic [3:0] GEN0 = 4'h8;
endpackage

// File: rtl/ck_encoder.sv
module ck_encoder
  import ck_pkg::*;
#(
  parameter int DSYM = 8
) (
  input  logic [DSYM*SYM_W-1:0]            data_i,
  output logic [(DSYM+CHK_SYMS)*SYM_W-1:0] code_o
);
  // remainder of d(x)*x^3 divided by the generator, unrolled
  always_comb begin
    logic [3:0] r0, r1, r2, fb;
    r0 = 4'h0;
    r1 = 4'h0;
    r2 = 4'h0;
    for (int i = DSYM - 1; i >= 0; i--) begin
      fb = data_i[i*SYM_W +: SYM_W] ^ r2;
      r2 = r1 ^ gf_mul(fb, GEN2);
      r1 = r0 ^ gf_mul(fb, GEN1);
      r0 = gf_mul(fb, GEN0);
    end
    code_o = {data_i, r2, r1, r0};
  end
endmodule

// File: rtl/ck_syndrome.sv
module ck_syndrome
  import ck_pkg::*;
#(
  parameter int NSYM = 11
) (
  input  logic [NSYM*SYM_W-1:0] code_i,
  output logic [3:0]            s_o [CHK_SYMS]
);
  // S_k = sum over positions i of c_i * alpha^(k*i)
  for (genvar k = 0; k < CHK_SYMS; k++) begin : g_syn
    always_comb begin
      logic [3:0] acc;
      acc = 4'h0;
      for (int i = 0; i < NSYM; i++)
        acc = acc ^ gf_mul(code_i[i*SYM_W +: SYM_W], gf_apow(k * i));
      s_o[k] = acc;
    end
  end
endmodule

// File: rtl/ck_locator.sv
module ck_locator
  import ck_pkg::*;
#(
  parameter int NSYM = 11,
  localparam int IW  = $clog2(NSYM)
) (
  input  logic [3:0]    s_i [CHK_SYMS],
  output logic          hit_o,
  output logic          bad_o,
  output logic [IW-1:0] pos_o,
  output logic [3:0]    val_o
);
  logic          any_nz;
  logic          consistent;
  logic [3:0]    ratio;
  logic [NSYM-1:0] match;

  assign any_nz     = (s_i[0] != 4'h0) || (s_i[1] != 4'h0) || (s_i[2] != 4'h0);
  assign consistent = (s_i[0] != 4'h0) &&
                      (gf_mul(s_i[1], s_i[1]) == gf_mul(s_i[0], s_i[2]));
  assign ratio      = gf_mul(s_i[1], gf_inv(s_i[0]));

  // compare the locator with every legal position of the shortened code
  for (genvar j = 0; j < NSYM; j++) begin : g_loc
    assign match[j] = consistent && (ratio == gf_apow(j));
  end

  always_comb begin
    pos_o = '0;
    for (int j = 0; j < NSYM; j++)
      if (match[j]) pos_o = IW'(j);
  end

  assign hit_o = |match;
  assign bad_o = any_nz && !hit_o;
  assign val_o = s_i[0];
endmodule

// File: rtl/ck_codec.sv
module ck_codec
  import ck_pkg::*;
#(
  parameter int DSYM  = 8,
  localparam int NSYM = DSYM + CHK_SYMS,
  localparam int DW   = DSYM * SYM_W,
  localparam int CW   = NSYM * SYM_W,
  localparam int IW   = $clog2(NSYM)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] enc_data_i,
  output logic [CW-1:0] enc_code_o,
  input  logic          dec_valid_i,
  input  logic [CW-1:0] dec_code_i,
  output logic          dec_valid_o,
  output logic [DW-1:0] dec_data_o,
  output logic          dec_corr_o,
  output logic          dec_uncorr_o,
  output logic [IW-1:0] dec_sym_o
);
  logic [3:0]    syn [CHK_SYMS];
  logic          hit, bad;
  logic [IW-1:0] pos;
  logic [3:0]    eval;
  logic [DW-1:0] fixed;

  ck_encoder #(.DSYM(DSYM)) u_enc (
    .data_i(enc_data_i),
    .code_o(enc_code_o)
  );

  ck_syndrome #(.NSYM(NSYM)) u_syn (
    .code_i(dec_code_i),
    .s_o   (syn)
  );

  ck_locator #(.NSYM(NSYM)) u_loc (
    .s_i  (syn),
    .hit_o(hit),
    .bad_o(bad),
    .pos_o(pos),
    .val_o(eval)
  );

  // repair the located data nibble; a check-symbol hit leaves data alone
  always_comb begin
    fixed = dec_code_i[CW-1 -: DW];
    for (int i = 0; i < DSYM; i++)
      if (hit && pos == IW'(i + CHK_SYMS))
        fixed[i*SYM_W +: SYM_W] = fixed[i*SYM_W +: SYM_W] ^ eval;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid_o  <= 1'b0;
      dec_data_o   <= '0;
      dec_corr_o   <= 1'b0;
      dec_uncorr_o <= 1'b0;
      dec_sym_o    <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o   <= fixed;
        dec_corr_o   <= hit;
        dec_uncorr_o <= bad;
        dec_sym_o    <= hit ? pos : '0;
      end
    end
  end
endmodule

// File: rtl/ck_codec_chk.sv
module ck_codec_chk #(
  parameter int DSYM = 8,
  localparam int NSYM = DSYM + 3,
  localparam int IW   = $clog2(NSYM)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 dec_valid_i,
  input logic                 dec_valid_o,
  input logic [DSYM*4-1:0]    dec_data_o,
  input logic                 dec_corr_o,
  input logic                 dec_uncorr_o,
  input logic [IW-1:0]        dec_sym_o
);
  a_r7_valid_rise: assert property (@(posedge clk) disable iff (rst)
    dec_valid_i |=> dec_valid_o);
  a_r7_valid_low: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> !dec_valid_o);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !dec_valid_i |=> ($stable(dec_data_o) && $stable(dec_corr_o) &&
                      $stable(dec_uncorr_o) && $stable(dec_sym_o)));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(dec_corr_o && dec_uncorr_o));
  a_r9_index_idle: assert property (@(posedge clk) disable iff (rst)
    !dec_corr_o |-> (dec_sym_o == '0));
  a_r4_index_range: assert property (@(posedge clk) disable iff (rst)
    dec_corr_o |-> (dec_sym_o < IW'(NSYM)));
endmodule

bind ck_codec ck_codec_chk #(.DSYM(DSYM)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dec_valid_i (dec_valid_i),
  .dec_valid_o (dec_valid_o),
  .dec_data_o  (dec_data_o),
  .dec_corr_o  (dec_corr_o),
  .dec_uncorr_o(dec_uncorr_o),
  .dec_sym_o   (dec_sym_o)
);

// File: tb/sim_ck_codec.sv
module sim_ck_codec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] enc_data_i = '0;
  logic [43:0] enc_code_o;
  logic        dec_valid_i = 1'b0;
  logic [43:0] dec_code_i = '0;
  logic        dec_valid_o;
  logic [31:0] dec_data_o;
  logic        dec_corr_o;
  logic        dec_uncorr_o;
  logic [3:0]  dec_sym_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  ck_codec u0 (
    .clk(clk), .rst(rst),
    .enc_data_i(enc_data_i), .enc_code_o(enc_code_o),
    .dec_valid_i(dec_valid_i), .dec_code_i(dec_code_i),
    .dec_valid_o(dec_valid_o), .dec_data_o(dec_data_o),
    .dec_corr_o(dec_corr_o), .dec_uncorr_o(dec_uncorr_o),
    .dec_sym_o(dec_sym_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic encode(input logic [31:0] d, output logic [43:0] c);
    @(negedge clk);
    enc_data_i = d;
    #1;
    c = enc_code_o;
  endtask

  // present one codeword, sample result one clock later
  task automatic decode(input logic [43:0] c, input logic [31:0] exp_d,
                        input bit exp_c, input bit exp_u, input logic [3:0] exp_s,
                        input string req);
    @(negedge clk);
    dec_code_i  = c;
    dec_valid_i = 1'b1;
    @(negedge clk);
    dec_valid_i = 1'b0;
    dec_code_i  = ~c;
    chk(dec_valid_o == 1'b1, req, "valid", 64'(dec_valid_o), 64'd1);
    chk(dec_data_o == exp_d && dec_corr_o == exp_c && dec_uncorr_o == exp_u &&
        dec_sym_o == exp_s, req, "data/corr/uncorr/sym",
        {dec_data_o, 23'd0, dec_corr_o, dec_uncorr_o, 3'd0, dec_sym_o},
        {exp_d, 23'd0, exp_c, exp_u, 3'd0, exp_s});
  endtask

  function automatic logic [43:0] inject(input logic [43:0] c, input int p,
                                         input logic [3:0] e);
    logic [43:0] r;
    r = c;
    r[p*4 +: 4] = r[p*4 +: 4] ^ e;
    return r;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(dec_valid_o == 0 && dec_corr_o == 0 && dec_uncorr_o == 0 &&
        dec_sym_o == 0 && dec_data_o == 0, "R8", "reset state",
        {dec_data_o, 25'd0, dec_valid_o, dec_corr_o, dec_uncorr_o, dec_sym_o}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_encoder_shape();
    logic [43:0] c;
    logic [31:0] pats [4] = '{32'h1234_5678, 32'hFFFF_FFFF, 32'h8000_0001, 32'hA5C3_0F96};
    foreach (pats[k]) begin
      encode(pats[k], c);
      chk(c[43:12] == pats[k], "R1", "data field", 64'(c[43:12]), 64'(pats[k]));
    end
    encode(32'h0, c);
    chk(c == 44'h0, "R2", "zero data code", 64'(c), 64'd0);
  endtask

  task automatic t_encoder_linear();
    logic [43:0] ca, cb, cx;
    logic [31:0] a, b;
    for (int k = 0; k < 6; k++) begin
      a = 32'h9E37_79B9 * (k + 1);
      b = 32'h7F4A_7C15 ^ (32'h0101_0101 << k);
      encode(a, ca);
      encode(b, cb);
      encode(a ^ b, cx);
      chk(cx == (ca ^ cb), "R2", "linearity", 64'(cx), 64'(ca ^ cb));
    end
  endtask

  task automatic t_clean();
    logic [43:0] c;
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      d = 32'hC0DE_0000 + 32'h1357_9BDF * k;
      encode(d, c);
      decode(c, d, 1'b0, 1'b0, 4'd0, "R3");
    end
  endtask

  task automatic t_single_data();
    logic [43:0] c;
    logic [31:0] d;
    logic [3:0] e;
    d = 32'h3C5A_96E1;
    encode(d, c);
    for (int p = 3; p < 11; p++) begin
      for (int v = 0; v < 3; v++) begin
        e = (v == 0) ? 4'hF : (v == 1) ? 4'h1 : 4'(((p * 3) % 15) + 1);
        decode(inject(c, p, e), d, 1'b1, 1'b0, 4'(p), "R4");
      end
    end
  endtask

  task automatic t_single_check();
    logic [43:0] c;
    logic [31:0] d;
    d = 32'hDEAD_BEEF;
    encode(d, c);
    for (int p = 0; p < 3; p++) begin
      decode(inject(c, p, 4'hF), d, 1'b1, 1'b0, 4'(p), "R5");
      decode(inject(c, p, 4'(p + 6)), d, 1'b1, 1'b0, 4'(p), "R5");
    end
  endtask

  task automatic t_double();
    logic [43:0] c, bad;
    logic [31:0] d;
    d = 32'h0F1E_2D3C;
    encode(d, c);
    for (int p = 0; p < 11; p++) begin
      for (int q = p + 1; q < 11; q++) begin
        bad = inject(inject(c, p, 4'((p % 15) + 1)), q, 4'(((q * 7) % 15) + 1));
        decode(bad, bad[43:12], 1'b0, 1'b1, 4'd0, "R6");
      end
    end
    bad = inject(inject(c, 4, 4'hF), 9, 4'hF);
    decode(bad, bad[43:12], 1'b0, 1'b1, 4'd0, "R6");
  endtask

  task automatic t_timing();
    logic [43:0] c;
    logic [31:0] d;
    d = 32'h55AA_33CC;
    encode(d, c);
    decode(inject(c, 6, 4'h9), d, 1'b1, 1'b0, 4'd6, "R7");
    @(negedge clk);
    chk(dec_valid_o == 1'b0, "R7", "valid drops", 64'(dec_valid_o), 64'd0);
    chk(dec_data_o == d && dec_corr_o && !dec_uncorr_o && dec_sym_o == 4'd6,
        "R7", "result held while idle", 64'(dec_data_o), 64'(d));
    chk(!(dec_corr_o && dec_uncorr_o), "R9", "flags exclusive",
        64'({dec_corr_o, dec_uncorr_o}), 64'd2);
  endtask

  initial begin
    t_reset();
    t_encoder_shape();
    t_encoder_linear();
    t_clean();
    t_single_data();
    t_single_check();
    t_double();
    t_timing();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule